// File: doc/BRIEF.md
# Keyed Write-Protect Gate

This block sits in front of the page buffer of a byte-writable nonvolatile memory and judges every byte-write cycle (an address and a data byte). For each write it raises one of two mutually exclusive verdicts in the same cycle: the byte may be loaded into the page buffer, or the byte is part of a keyed command and must be dropped. Writes that are neither are blocked.

The block holds a protection flag that survives its own reset. It is cleared only by a keyed command, and it powers up cleared. A three-byte arming key sets protection and opens a window for exactly one page load. The window closes when the page logic reports that the load has ended, and protection stays in force afterwards. A six-byte release key shares its first two bytes with the arming key. It clears protection at the next page-end report, that is, once the programming time that follows it has passed. Only the low fifteen address bits take part in key matching.

Top module: `swp_gate`

## Requirements
- R1: The arming key (data 0xAA at address 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555) marks each of its three writes with wr_cmd=1 and wr_allow=0. After the third byte, protection is set and a page window is open.
- R2: While the page window is open, every non-command write gets wr_allow=1. A page_done pulse closes the window, and later plain writes are blocked because protection stays set.
- R3: While protection is set and no window is open, a write that is not part of a key gets wr_allow=0 and wr_cmd=0.
- R4: While protection is clear, a write that is not part of a key gets wr_allow=1 and wr_cmd=0.
- R5: Address bits 15 and above are ignored in key matching, so 0xD555 and 0xAAAA match the key addresses.
- R6: A write that breaks a partly matched key returns the matcher to idle. That write is judged under the current protection state and gets wr_cmd=0. It does not start a new key.
- R7: The release key (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555) marks all six writes with wr_cmd=1. Writes stay blocked until the next page_done pulse, after which protection is clear.
- R8: The arming key used while protection is already set opens a fresh page window and cancels any pending release.
- R9: rst clears the matcher and the page window. It leaves the protection flag unchanged, and both verdicts read 0 while rst is high.
- R10: While the page window is open the matcher is suspended, so a data byte equal to a key byte is loaded (wr_allow=1, wr_cmd=0).
- R11: With wr_valid low, both wr_allow and wr_cmd are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch protection |
| wr_valid | input | 1 | A byte-write cycle is presented this clock |
| wr_addr | input | ADDR_W (16) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| page_done | input | 1 | Pulse: the current page load has ended and its programming time has elapsed |
| wr_allow | output | 1 | This write may be loaded into the page buffer |
| wr_cmd | output | 1 | This write belongs to a key and must not be stored |

## Verification
On every cycle the assertions check these properties. The two verdicts never coincide, and they are silent when no write is presented. An open window implies protection. Protection only falls on a page-end report after a completed release key, and a reset cycle never moves it. The matcher is never mid-key while a window is open. Only the bench's scenarios can show that the key bytes are decoded in the right order with the right values, and that a broken key is judged under the correct state. They also show that the ignored upper address bit, re-arming, and persistence across reset behave as required.

// File: rtl/swp_pkg.sv
package swp_pkg;

    parameter int ADDR_W  = 16;
    parameter int DATA_W  = 8;
    parameter int KEY_AW  = 15;   // address bits that take part in matching

    // Matcher position: how many key bytes have been accepted so far.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_K1   = 3'd1,
        ST_K2   = 3'd2,
        ST_D3   = 3'd3,
        ST_D4   = 3'd4,
        ST_D5   = 3'd5
    } step_e;

    typedef struct packed {
        logic [KEY_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } key_t;

    // Distinct key bytes used by both commands.
    typedef enum int {
        KB_LEAD  = 0,   // 0xAA @ 0x5555
        KB_SECND = 1,   // 0x55 @ 0x2AAA
        KB_ARM   = 2,   // 0xA0 @ 0x5555
        KB_REL   = 3,   // 0x80 @ 0x5555
        KB_FIN   = 4    // 0x20 @ 0x5555
    } kbyte_e;

    localparam int NKB = 5;

    localparam logic [KEY_AW-1:0] KA_HI = 15'h5555;
    localparam logic [KEY_AW-1:0] KA_LO = 15'h2AAA;

    function automatic key_t key_at(input int idx);
        key_t k;
        case (idx)
            KB_LEAD:  k = '{addr: KA_HI, data: 8'hAA};
            KB_SECND: k = '{addr: KA_LO, data: 8'h55};
            KB_ARM:   k = '{addr: KA_HI, data: 8'hA0};
            KB_REL:   k = '{addr: KA_HI, data: 8'h80};
            default:  k = '{addr: KA_HI, data: 8'h20};
        endcase
        return k;
    endfunction

    // Result of judging one write against the key stream.
    typedef struct packed {
        logic hit;     // write consumed as a key byte
        logic arm;     // final byte of the arming key
        logic rel;     // final byte of the release key
    } match_t;

endpackage

// File: rtl/swp_keycmp.sv
module swp_keycmp
    import swp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  data,
    output logic [NKB-1:0] kb_hit
);
    localparam int LOW_W = KEY_AW;

    logic [LOW_W-1:0] addr_low;
    assign addr_low = addr[LOW_W-1:0];

    for (genvar g = 0; g < NKB; g++) begin : g_cmp
        localparam key_t K = key_at(g);
        assign kb_hit[g] = (addr_low == K.addr) && (data == K.data);
    end

endmodule

// File: rtl/swp_matcher.sv
module swp_matcher
    import swp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          suspend,
    output match_t        verdict
);
    logic [NKB-1:0] kb;
    step_e          step_q, step_d;
    match_t         m;

    swp_keycmp #(.AW(AW), .DW(DW)) i_cmp (
        .addr   (wr_addr),
        .data   (wr_data),
        .kb_hit (kb)
    );

    always_comb begin
        m      = '0;
        step_d = step_q;
        if (wr_valid && !suspend) begin
            step_d = ST_IDLE;
            unique case (step_q)
                ST_IDLE: if (kb[KB_LEAD])  begin m.hit = 1'b1; step_d = ST_K1; end
                ST_K1:   if (kb[KB_SECND]) begin m.hit = 1'b1; step_d = ST_K2; end
                ST_K2: begin
                    if (kb[KB_ARM]) begin
                        m.hit = 1'b1; m.arm = 1'b1;
                    end else if (kb[KB_REL]) begin
                        m.hit = 1'b1; step_d = ST_D3;
                    end
                end
                ST_D3:   if (kb[KB_LEAD])  begin m.hit = 1'b1; step_d = ST_D4; end
                ST_D4:   if (kb[KB_SECND]) begin m.hit = 1'b1; step_d = ST_D5; end
                ST_D5:   if (kb[KB_FIN])   begin m.hit = 1'b1; m.rel = 1'b1; end
                default: step_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_IDLE;
        else     step_q <= step_d;
    end

    assign verdict = m;

    // R10
    mid_key_no_window_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q != ST_IDLE) |-> !suspend);

    // R6
    done_returns_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (m.arm || m.rel) |=> (step_q == ST_IDLE));

endmodule

// File: rtl/swp_state.sv
module swp_state (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic rel,
    input  logic page_done,
    output logic prot,
    output logic window
);
    // Protection is deliberately outside the reset domain: it powers up clear
    // and only a completed release key followed by page_done clears it.
    logic prot_q = 1'b0;
    logic win_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst) begin
            if (page_done && pend_q) prot_q <= 1'b0;
            if (arm)                 prot_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (page_done) begin
                win_q  <= 1'b0;
                pend_q <= 1'b0;
            end
            if (rel) pend_q <= 1'b1;
            if (arm) begin
                win_q  <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    assign prot   = prot_q;
    assign window = win_q;

    // R2
    window_needs_prot_chk: assert property (@(posedge clk) disable iff (rst)
        win_q |-> prot_q);

    // R1
    arm_opens_window_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (win_q && prot_q));

    // R7
    prot_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_q) |-> $past(pend_q && page_done));

    // R9
    reset_keeps_prot_chk: assert property (@(posedge clk)
        $past(rst) |-> (prot_q == $past(prot_q)));

endmodule

// File: rtl/swp_gate.sv
module swp_gate
    import swp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          page_done,
    output logic          wr_allow,
    output logic          wr_cmd
);
    logic   valid_eff;
    logic   prot, window;
    match_t verdict;

    assign valid_eff = wr_valid && !rst;

    swp_matcher #(.AW(AW), .DW(DW)) i_match (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (valid_eff),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .suspend  (window),
        .verdict  (verdict)
    );

    swp_state i_state (
        .clk       (clk),
        .rst       (rst),
        .arm       (verdict.arm),
        .rel       (verdict.rel),
        .page_done (page_done),
        .prot      (prot),
        .window    (window)
    );

    assign wr_cmd   = verdict.hit;
    assign wr_allow = valid_eff && !verdict.hit && (!prot || window);

    // R11
    idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (!wr_allow && !wr_cmd));

    // R3
    locked_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (prot && !window) |-> !wr_allow);

    // R10
    window_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        window |-> !wr_cmd);

endmodule

// File: tb/test_swp_gate.sv
module test_swp_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        page_done = 1'b0;
    logic        wr_allow, wr_cmd;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_n = 0;
    bit m_prot = 0, m_win = 0, m_pend = 0;
    int arm_a[3] = '{'h5555, 'h2AAA, 'h5555};
    int arm_d[3] = '{'hAA, 'h55, 'hA0};
    int rel_a[6] = '{'h5555, 'h2AAA, 'h5555, 'h5555, 'h2AAA, 'h5555};
    int rel_d[6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h20};

    always #10 clk = ~clk;   // 50 MHz

    swp_gate i_swp_gate (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .page_done(page_done),
        .wr_allow(wr_allow), .wr_cmd(wr_cmd)
    );

    function automatic bit km(int a, int d, int ka, int kd);
        return ((a & 'h7FFF) == ka) && (d == kd);
    endfunction

    task automatic cyc(input bit r, input bit v, input int a, input int d,
                       input bit pd, input string tag);
        bit en_ok = 0, rel_ok = 0, e_cmd = 0, e_allow = 0;
        @(negedge clk);
        rst = r; wr_valid = v; wr_addr = a[15:0]; wr_data = d[7:0]; page_done = pd;
        if (v && !r) begin
            if (!m_win) begin
                en_ok  = (m_n < 3) && km(a, d, arm_a[m_n], arm_d[m_n]);
                rel_ok = (m_n < 6) && km(a, d, rel_a[m_n], rel_d[m_n]);
            end
            if (en_ok || rel_ok) e_cmd = 1;
            else e_allow = !m_prot || m_win;
        end
        #5;
        vectors++;
        if (wr_cmd !== e_cmd || wr_allow !== e_allow) begin
            miscompares++;
            $display("FAIL %s: addr=%h data=%h allow=%b cmd=%b expected allow=%b cmd=%b",
                     tag, a[15:0], d[7:0], wr_allow, wr_cmd, e_allow, e_cmd);
        end
        @(posedge clk);
        if (r) begin
            m_n = 0; m_win = 0; m_pend = 0;
        end else begin
            bit ev_en = 0, ev_rel = 0;
            if (v && !m_win) begin
                if (en_ok && m_n == 2)       begin ev_en = 1;  m_n = 0; end
                else if (rel_ok && m_n == 5) begin ev_rel = 1; m_n = 0; end
                else if (en_ok || rel_ok)    m_n++;
                else                         m_n = 0;
            end
            if (pd) begin
                m_win = 0;
                if (m_pend) m_prot = 0;
                m_pend = 0;
            end
            if (ev_rel) m_pend = 1;
            if (ev_en) begin m_prot = 1; m_win = 1; m_pend = 0; end
        end
    endtask

    task automatic arm_key(input int hi, input int lo, input string tag);
        cyc(0, 1, hi, 'hAA, 0, tag);
        cyc(0, 1, lo, 'h55, 0, tag);
        cyc(0, 1, hi, 'hA0, 0, tag);
    endtask

    task automatic release_key(input string tag);
        cyc(0, 1, 'h5555, 'hAA, 0, tag);
        cyc(0, 1, 'h2AAA, 'h55, 0, tag);
        cyc(0, 1, 'h5555, 'h80, 0, tag);
        cyc(0, 1, 'h5555, 'hAA, 0, tag);
        cyc(0, 1, 'h2AAA, 'h55, 0, tag);
        cyc(0, 1, 'h5555, 'h20, 0, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        // R9 R11: reset and idle
        cyc(1, 1, 'h0100, 'h12, 0, "R9");
        cyc(1, 0, 0, 0, 0, "R9");
        cyc(0, 0, 'h5555, 'hAA, 0, "R11");
        // R4: unprotected plain writes
        cyc(0, 1, 'h0100, 'h12, 0, "R4");
        cyc(0, 1, 'hFFFF, 'h00, 0, "R4");
        // R6 unprotected break: AA then plain data
        cyc(0, 1, 'h5555, 'hAA, 0, "R6");
        cyc(0, 1, 'h0200, 'h33, 0, "R6");
        // R1 arm, R10 key byte as data in window, R2 window then close
        arm_key('h5555, 'h2AAA, "R1");
        cyc(0, 1, 'h0300, 'h44, 0, "R2");
        cyc(0, 1, 'h5555, 'hAA, 0, "R10");
        cyc(0, 1, 'h2AAA, 'h55, 0, "R10");
        cyc(0, 0, 0, 0, 1, "R2");
        // R3 locked
        cyc(0, 1, 'h0300, 'h45, 0, "R3");
        cyc(0, 1, 'h1234, 'h5A, 0, "R3");
        // R5 R8 re-arm with bit 15 set
        arm_key('hD555, 'hAAAA, "R5");
        cyc(0, 1, 'h8000, 'h66, 0, "R8");
        cyc(0, 1, 'h8001, 'h67, 1, "R8");
        cyc(0, 1, 'h8002, 'h68, 0, "R3");
        // R6 protected breaks at several depths
        cyc(0, 1, 'h5555, 'hAA, 0, "R6");
        cyc(0, 1, 'h2AAA, 'h55, 0, "R6");
        cyc(0, 1, 'h0010, 'h77, 0, "R6");
        cyc(0, 1, 'h2AAA, 'h55, 0, "R6");
        cyc(0, 1, 'h5555, 'hAA, 0, "R6");
        cyc(0, 1, 'h1234, 'h11, 0, "R6");
        cyc(0, 1, 'h5555, 'hAA, 0, "R6");
        cyc(0, 1, 'h2AAA, 'h55, 0, "R6");
        cyc(0, 1, 'h5555, 'h80, 0, "R6");
        cyc(0, 1, 'h5555, 'hAA, 0, "R6");
        cyc(0, 1, 'h5555, 'h20, 0, "R6");
        // R9: protection persists over reset
        cyc(1, 0, 0, 0, 0, "R9");
        cyc(0, 1, 'h0400, 'h01, 0, "R9");
        // R7 release: blocked until page_done, then open
        release_key("R7");
        cyc(0, 1, 'h0500, 'h02, 0, "R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 1, 'h0500, 'h03, 0, "R7");
        // R8: arming cancels a pending release
        arm_key('h5555, 'h2AAA, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        release_key("R8");
        arm_key('h5555, 'h2AAA, "R8");
        cyc(0, 0, 0, 0, 1, "R8");
        cyc(0, 1, 'h0600, 'h04, 0, "R8");
        // R9: reset mid-key clears the matcher
        release_key("R7");
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(0, 1, 'h5555, 'hAA, 0, "R9");
        cyc(1, 0, 0, 0, 0, "R9");
        cyc(0, 1, 'h2AAA, 'h55, 0, "R9");
        cyc(0, 1, 'h0700, 'h05, 0, "R4");
        // R9: reset closes an open window
        arm_key('h5555, 'h2AAA, "R1");
        cyc(1, 0, 0, 0, 0, "R9");
        cyc(0, 1, 'h0800, 'h06, 0, "R9");
        summary();
    end

endmodule